// File: doc/BRIEF.md
# Time-Shared Multiply-Add Datapath

This block evaluates z = a*b + (c + d) on unsigned operands using exactly one two-cycle multiplier and one single-cycle adder. A small control-step state machine steers both units: a pair of operand muxes feeds the adder either the stored c and d or the intermediate product x and partial sum y. A result demux then writes the adder output either back into y or into the output register z.

Operands arrive with a valid/ready handshake. They are captured on the clock edge where both valid and ready are high. Each finished result is announced by a one-cycle valid flag on z. A build-time parameter selects one of two schedules:

- **Sequential schedule:** three control steps per result.
- **Overlapped schedule:** the product and the c+d sum are formed in the same step, and the final addition shares its step with capture of the next operands. This gives two cycles per result in a continuous stream.

Top module: `madd_sched`

## Requirements
- R1: For every accepted operand set, z_o equals a*b + c + d computed without truncation. z_o is 2W+1 bits wide, and its top bit is never set when z_valid_o is high.
- R2: While rst_ni is low, in_ready_o is 1, z_valid_o is 0 and z_o is 0.
- R3: Operands are captured only on a rising edge where in_valid_i and in_ready_o are both 1. Values presented while in_ready_o is 0 have no effect on any result. in_ready_o is 0 in the cycle after a capture and stays 0 until the final step of that result.
- R4: z_o and z_valid_o update on the 2nd rising edge after the capturing edge when OVERLAP=1, and on the 3rd when OVERLAP=0.
- R5: With in_valid_i held high, operand sets are captured every 2 cycles (OVERLAP=1) or every 3 cycles (OVERLAP=0). n results therefore take 2n+1 or 3n+1 cycles counted from the first capture cycle.
- R6: z_valid_o is high for exactly one cycle per result. z_o keeps its value until the next result is written.
- R7: If in_valid_i is low in the final step, the block returns to idle. in_ready_o is then 1 from at most 3 cycles after the last capture, and no result appears without a matching capture.
- R8: The adder takes c and d when the operand select is 1 and takes x and y when it is 0. The sum goes to y when the demux select is 1 and to z when it is 0. The final step of every result always adds x and y into z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand set present |
| in_ready_o | output | 1 | Block can capture operands this cycle |
| a_i | input | W | Multiplicand |
| b_i | input | W | Multiplier |
| c_i | input | W | First addend |
| d_i | input | W | Second addend |
| z_o | output | 2W+1 | Result register |
| z_valid_o | output | 1 | One-cycle strobe, z_o holds a new result |

## Verification
A control step taken out of turn corrupts the value in z_o. It also moves z_valid_o off the cycle predicted from the capture edge, so the fault shows at the first result after the bad step. That is two or three cycles after capture. A stuck or mis-sequenced state machine shows even sooner, as in_ready_o being high inside the busy window or low after the idle window. With W=3, every one of the 4096 operand combinations is pushed through both schedules. Garbage is driven while ready is low and idle gaps are inserted, so each path through the state machine is checked against arithmetic computed in the bench.

// File: rtl/madd_pkg.sv
package madd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_ADD_CD,
    ST_PAIR,
    ST_SUM
  } step_e;
endpackage

// File: rtl/madd_mul2.sv
// Two-cycle multiplier: partial products captured with the operands, combined into x.
module madd_mul2 #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_in_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           ld_x_i,
  output logic [2*W-1:0] x_o
);
  localparam int PW = 2 * W;
  localparam int HW = (W > 1) ? W / 2 : 1;

  logic [PW-1:0] pp_lo_q, pp_hi_q, x_q;
  logic [PW-1:0] pp_lo_d, pp_hi_d;

  generate
    if (W > 1) begin : g_split
      always_comb begin
        pp_lo_d = PW'(a_i) * PW'(b_i[HW-1:0]);
        pp_hi_d = PW'(a_i) * PW'(b_i[W-1:HW]);
      end
    end else begin : g_bit
      always_comb begin
        pp_lo_d = PW'(a_i & b_i);
        pp_hi_d = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_lo_q <= '0;
      pp_hi_q <= '0;
    end else if (ld_in_i) begin
      pp_lo_q <= pp_lo_d;
      pp_hi_q <= pp_hi_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     x_q <= '0;
    else if (ld_x_i) x_q <= pp_lo_q + (pp_hi_q << HW);
  end

  assign x_o = x_q;
endmodule

// File: rtl/madd_addpath.sv
// Shared adder with operand muxes, result demux and the c, d, y, z registers.
module madd_addpath #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_in_i,
  input  logic [W-1:0]   c_i,
  input  logic [W-1:0]   d_i,
  input  logic [2*W-1:0] x_i,
  input  logic           sel_cd_i,
  input  logic           route_y_i,
  input  logic           ld_y_i,
  input  logic           ld_z_i,
  output logic [2*W:0]   z_o,
  output logic           z_valid_o
);
  localparam int ZW = 2 * W + 1;

  logic [W-1:0]  c_q, d_q;
  logic [ZW-1:0] y_q, z_q;
  logic [ZW-1:0] op_a, op_b, sum;
  logic          wr_y, wr_z;
  logic          zv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= '0;
      d_q <= '0;
    end else if (ld_in_i) begin
      c_q <= c_i;
      d_q <= d_i;
    end
  end

  always_comb begin
    op_a = sel_cd_i ? ZW'(c_q) : ZW'(x_i);
    op_b = sel_cd_i ? ZW'(d_q) : y_q;
    sum  = op_a + op_b;
    wr_y = ld_y_i && route_y_i;
    wr_z = ld_z_i && !route_y_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q  <= '0;
      z_q  <= '0;
      zv_q <= 1'b0;
    end else begin
      if (wr_y) y_q <= sum;
      if (wr_z) z_q <= sum;
      zv_q <= wr_z;
    end
  end

  assign z_o       = z_q;
  assign z_valid_o = zv_q;
endmodule

// File: rtl/madd_ctrl.sv
// Control-step FSM; OVERLAP picks the two-step or three-step schedule.
module madd_ctrl #(
  parameter bit OVERLAP = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic ld_in_o,
  output logic ld_x_o,
  output logic sel_cd_o,
  output logic route_y_o,
  output logic ld_y_o,
  output logic ld_z_o
);
  import madd_pkg::*;

  localparam step_e FIRST = OVERLAP ? ST_PAIR : ST_MUL;

  step_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    in_ready_o = 1'b0;
    ld_x_o     = 1'b0;
    sel_cd_o   = 1'b0;
    route_y_o  = 1'b0;
    ld_y_o     = 1'b0;
    ld_z_o     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        in_ready_o = 1'b1;
        if (in_valid_i) st_d = FIRST;
      end
      ST_MUL: begin
        ld_x_o = 1'b1;
        st_d   = ST_ADD_CD;
      end
      ST_ADD_CD: begin
        sel_cd_o  = 1'b1;
        route_y_o = 1'b1;
        ld_y_o    = 1'b1;
        st_d      = ST_SUM;
      end
      ST_PAIR: begin
        ld_x_o    = 1'b1;
        sel_cd_o  = 1'b1;
        route_y_o = 1'b1;
        ld_y_o    = 1'b1;
        st_d      = ST_SUM;
      end
      ST_SUM: begin
        ld_z_o     = 1'b1;
        in_ready_o = 1'b1;
        st_d       = in_valid_i ? FIRST : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign ld_in_o = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/madd_sched.sv
module madd_sched #(
  parameter int W       = 8,
  parameter bit OVERLAP = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   c_i,
  input  logic [W-1:0]   d_i,
  output logic [2*W:0]   z_o,
  output logic           z_valid_o
);
  logic           ld_in, ld_x, sel_cd, route_y, ld_y, ld_z;
  logic [2*W-1:0] x;

  madd_ctrl #(.OVERLAP(OVERLAP)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .ld_in_o    (ld_in),
    .ld_x_o     (ld_x),
    .sel_cd_o   (sel_cd),
    .route_y_o  (route_y),
    .ld_y_o     (ld_y),
    .ld_z_o     (ld_z)
  );

  madd_mul2 #(.W(W)) i_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_in_i (ld_in),
    .a_i     (a_i),
    .b_i     (b_i),
    .ld_x_i  (ld_x),
    .x_o     (x)
  );

  madd_addpath #(.W(W)) i_add (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_in_i   (ld_in),
    .c_i       (c_i),
    .d_i       (d_i),
    .x_i       (x),
    .sel_cd_i  (sel_cd),
    .route_y_i (route_y),
    .ld_y_i    (ld_y),
    .ld_z_i    (ld_z),
    .z_o       (z_o),
    .z_valid_o (z_valid_o)
  );
endmodule

// File: rtl/madd_sched_chk.sv
module madd_sched_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic [2*W:0] z_o,
  input logic         z_valid_o,
  input logic         sel_cd_i,
  input logic         route_y_i,
  input logic         ld_y_i,
  input logic         ld_z_i
);
  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_valid_o |-> !z_o[2*W]);

  p_busy_after_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  p_single_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_valid_o |=> !z_valid_o);

  p_z_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(z_o) |-> z_valid_o);

  p_stay_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && in_ready_o) |=> in_ready_o);

  p_sum_xy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_z_i |-> (!sel_cd_i && !route_y_i && !ld_y_i));

  p_y_from_cd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_y_i |-> (sel_cd_i && route_y_i && !ld_z_i));
endmodule

bind madd_sched madd_sched_chk #(.W(W)) i_madd_sched_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .z_o        (z_o),
  .z_valid_o  (z_valid_o),
  .sel_cd_i   (sel_cd),
  .route_y_i  (route_y),
  .ld_y_i     (ld_y),
  .ld_z_i     (ld_z)
);

// File: tb/madd_lane.sv
`timescale 1ns/1ps
// One schedule variant driven through all W=3 operand combinations.
module madd_lane #(
  parameter bit OVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_fail,
  output logic done
);
  localparam int W  = 3;
  localparam int NV = 1 << (4 * W);
  localparam int L  = OVL ? 2 : 3;   // edges from capture to result
  localparam int P  = OVL ? 2 : 3;   // cycles per result when streaming

  logic           in_valid, in_ready, z_valid;
  logic [W-1:0]   a, b, c, d;
  logic [2*W:0]   z;

  madd_sched #(.W(W), .OVERLAP(OVL)) i_madd_sched (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .a_i        (a),
    .b_i        (b),
    .c_i        (c),
    .d_i        (d),
    .z_o        (z),
    .z_valid_o  (z_valid)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int exp_z [NV];
  int exp_t [NV];
  int acc_n = 0, res_n = 0, last_acc = 0, quiet = 0;
  bit prev_zv = 0, stream = 0, final_done = 0;

  initial begin
    n_chk  = 0;
    n_fail = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s ovl=%0d cyc=%0d actual=%0d expected=%0d", req, OVL, cyc, act, exp);
    end
  endtask

  // Driver
  initial begin
    in_valid = 1'b0;
    a = '0; b = '0; c = '0; d = '0;
    done = 1'b0;
    @(posedge rst_n);
    for (int v = 0; v < NV; v++) begin
      forever begin
        @(negedge clk);
        in_valid = 1'b1;
        if (in_ready) begin
          a = v[2:0]; b = v[5:3]; c = v[8:6]; d = v[11:9];
          break;
        end else begin
          a = 3'(v * 5 + 3); b = 3'(~v); c = 3'(v + 6); d = 3'(v * 3 + 1);
        end
      end
      if (v % 11 == 5) begin
        repeat (4) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    done = 1'b1;
  end

  // Monitor, sampled after the driver has settled
  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      chk(in_ready == 1'b1, "R2 ready", int'(in_ready), 1);
      chk(z_valid == 1'b0, "R2 z_valid", int'(z_valid), 0);
      chk(z == '0, "R2 z", int'(z), 0);
    end else begin
      if (z_valid) begin
        if (prev_zv) chk(1'b0, "R6 strobe width", 1, 0);
        if (res_n >= acc_n) begin
          chk(1'b0, "R7 result without capture", res_n, acc_n);
        end else begin
          chk(int'(z) == exp_z[res_n], "R1 R8 value", int'(z), exp_z[res_n]);
          chk(z[2*W] == 1'b0, "R1 top bit", int'(z[2*W]), 0);
          chk(cyc == exp_t[res_n], "R4 latency", cyc, exp_t[res_n]);
          res_n++;
        end
      end else if (res_n > 0) begin
        chk(int'(z) == exp_z[res_n-1], "R6 hold", int'(z), exp_z[res_n-1]);
      end
      prev_zv = z_valid;

      if (acc_n > 0 && (cyc + 1 - last_acc) < P)
        chk(in_ready == 1'b0, "R3 busy", int'(in_ready), 0);

      if (in_valid && in_ready) begin
        exp_z[acc_n] = int'(a) * int'(b) + int'(c) + int'(d);
        exp_t[acc_n] = cyc + 1 + L;
        if (acc_n > 0 && stream)
          chk((cyc + 1 - last_acc) == P, "R5 spacing", cyc + 1 - last_acc, P);
        last_acc = cyc + 1;
        stream = 1'b1;
        acc_n++;
      end
      if (!in_valid) begin
        stream = 1'b0;
        quiet++;
        if (quiet >= 3) chk(in_ready == 1'b1, "R7 idle ready", int'(in_ready), 1);
      end else begin
        quiet = 0;
      end

      if (done && !final_done) begin
        final_done = 1'b1;
        chk(acc_n == NV, "R3 capture count", acc_n, NV);
        chk(res_n == NV, "R7 result count", res_n, NV);
      end
    end
  end
endmodule

// File: tb/test_madd_sched.sv
`timescale 1ns/1ps
module test_madd_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int   chk_s, fail_s, chk_o, fail_o;
  logic done_s, done_o;
  int   checks, failures;
  bit   wd = 0;

  madd_lane #(.OVL(1'b0)) i_lane_seq (
    .clk(clk), .rst_n(rst_n), .n_chk(chk_s), .n_fail(fail_s), .done(done_s)
  );

  madd_lane #(.OVL(1'b1)) i_lane_ovl (
    .clk(clk), .rst_n(rst_n), .n_chk(chk_o), .n_fail(fail_o), .done(done_o)
  );

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done_s && done_o);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (60000) @(posedge clk);
        wd = 1;
      end
    join_any
    checks   = chk_s + chk_o;
    failures = fail_s + fail_o;
    if (wd) begin
      checks++;
      failures++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule